// File: doc/BRIEF.md
# Flash Interrupt and Status Registers

This block holds the register-side interrupt and status state of a NAND-style flash controller. It keeps an interrupt status word, a controller status word with four latched error flags, and two system configuration words. It drives an interrupt pin whose polarity is programmable and a ready pin. A command engine reports completions and failures on a small event port. The block folds those reports into the interrupt and status words.

Software reaches the block through a single-cycle register port. A write updates the selected register, and a combinational read returns the selected register with its read mask applied. A write to the command register is screened here. It is dropped while an interrupt is still pending. An unknown opcode is turned into a command error. Only a known opcode produces a one-cycle start strobe towards the engine. The asynchronous reset gives the cold reset values. A synchronous warm-reset input gives the warm or hot values.

Top module: `flash_irq_regs`

## Requirements
- R1: After the asynchronous cold reset, the interrupt status reads 0x8080. Configuration-1 reads 0x40C0, configuration-2 and controller status read 0x0000, the last-command register reads 0x00, ready is 1 and the interrupt pin is 1.
- R2: A cycle with warm_rst_i high sets the interrupt status to 0x8010, returns both configuration words to their reset values, clears controller status and the last command, and sets ready to 1.
- R3: The interrupt pin equals interrupt status bit 15 XOR NOT configuration-1 bit 6. With bit 6 set the pin is active high, with bit 6 clear it is active low. The pin changes in the same cycle as the register update that affects it.
- R4: A write to the interrupt register (address 0) replaces the interrupt status with the old value ANDed with the written data.
- R5: When an interrupt register write leaves bit 15 at 0, status bits 10 to 13 are cleared. When bit 15 stays 1, they are kept.
- R6: An engine event sets interrupt bit 15 and one done bit: bit 5 for kind 0 (erase), bit 6 for kind 1 (program), bit 7 for kind 2 (load), and no done bit for kind 3 (other).
- R7: An event with evt_err_i set adds status bit 10 (command error) plus bit 11 for erase, bit 12 for program or bit 13 for load. Kind 3 adds bit 10 only.
- R8: The ready pin takes configuration-1 bit 7 when configuration-1 (address 2) is written, and holds its value otherwise.
- R9: A read of configuration-1 returns the stored word ANDed with 0xFFE0. Configuration-2 (address 3) reads back all 16 bits.
- R10: A command write (address 4) made while interrupt bit 15 is 1 is dropped. It gives no start strobe and leaves the last-command register and the status unchanged.
- R11: A command write with bit 15 clear and an opcode outside the known set gives no start strobe. At the next edge it sets interrupt bit 15 and status bit 10. The known set is 00, 13, 80, 1A, 1B, 23, 27, 2A, 2C, 71, 95, 94, B0, 30, F0, F3 and 65 (hex).
- R12: A command write with bit 15 clear and a known opcode raises cmd_start_o in the same cycle, with cmd_o equal to the opcode. The opcode then reads back at address 4.
- R13: Writes to the controller status register (address 1) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low cold reset |
| warm_rst_i | input | 1 | Synchronous warm/hot reset |
| addr_i | input | 3 | Register select: 0 interrupt, 1 status, 2 config-1, 3 config-2, 4 command |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Masked read data of the selected register |
| evt_valid_i | input | 1 | Engine completion event |
| evt_kind_i | input | 2 | Event kind: 0 erase, 1 program, 2 load, 3 other |
| evt_err_i | input | 1 | Event reports a failure |
| cmd_start_o | output | 1 | One-cycle start strobe for an accepted command |
| cmd_o | output | 8 | Opcode presented with the strobe |
| irq_o | output | 1 | Interrupt pin, polarity set by config-1 bit 6 |
| rdy_o | output | 1 | Ready pin |

## Verification
The bench first targets error clearing, which is keyed to the result of the AND-mask write rather than to the data written. A design that tested the written bit 15 alone, or that cleared errors on any write, would lose or keep flags wrongly. It then drives an event in the same cycle as a clearing write, to show that the new report survives the clear. Command screening is checked with bit 15 set and then clear, and with known and unknown opcodes. A gate that ignored the pending interrupt, or that strobed unknown opcodes, would fire the engine. The interrupt pin is checked under both polarities, and the ready pin is checked for holding through other writes.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int REG_W  = 16;
  localparam int CMD_W  = 8;
  localparam int ADDR_W = 3;

  localparam int INT_MASTER = 15;
  localparam int INT_ERASE  = 5;
  localparam int INT_PROG   = 6;
  localparam int INT_LOAD   = 7;
  localparam int ST_CMD     = 10;
  localparam int ST_ERASE   = 11;
  localparam int ST_PROG    = 12;
  localparam int ST_LOAD    = 13;
  localparam int CFG_POL    = 6;
  localparam int CFG_RDY    = 7;

  localparam logic [REG_W-1:0] INT_COLD_VAL = 16'h8080;
  localparam logic [REG_W-1:0] INT_WARM_VAL = 16'h8010;
  localparam logic [REG_W-1:0] CFG1_RST_VAL = 16'h40C0;
  localparam logic [REG_W-1:0] CFG2_RST_VAL = 16'h0000;
  localparam logic [REG_W-1:0] CFG1_RD_MASK = 16'hFFE0;
  localparam logic [REG_W-1:0] ST_ERR_MASK  =
    (REG_W'(1) << ST_CMD) | (REG_W'(1) << ST_ERASE) |
    (REG_W'(1) << ST_PROG) | (REG_W'(1) << ST_LOAD);

  typedef enum logic [ADDR_W-1:0] {
    RA_INT  = 3'd0,
    RA_STAT = 3'd1,
    RA_CFG1 = 3'd2,
    RA_CFG2 = 3'd3,
    RA_CMD  = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    EV_ERASE = 2'd0,
    EV_PROG  = 2'd1,
    EV_LOAD  = 2'd2,
    EV_OTHER = 2'd3
  } evt_kind_e;

  function automatic logic cmd_known(input logic [CMD_W-1:0] op);
    case (op)
      8'h00, 8'h13, 8'h80, 8'h1A, 8'h1B, 8'h23, 8'h27, 8'h2A, 8'h2C,
      8'h71, 8'h95, 8'h94, 8'hB0, 8'h30, 8'hF0, 8'hF3, 8'h65: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/flash_int_ctrl.sv
module flash_int_ctrl
  import flash_irq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         warm_i,
  input  logic         int_we_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         evt_valid_i,
  input  logic [1:0]   evt_kind_i,
  input  logic         evt_err_i,
  input  logic         unk_cmd_i,
  output logic [W-1:0] int_o,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] int_q, stat_q, int_d, stat_d;
  logic [W-1:0] int_masked, stat_kept, int_set, err_set;

  always_comb begin
    int_set = '0;
    err_set = '0;
    if (evt_valid_i) begin
      int_set[INT_MASTER] = 1'b1;
      case (evt_kind_e'(evt_kind_i))
        EV_ERASE: int_set[INT_ERASE] = 1'b1;
        EV_PROG:  int_set[INT_PROG]  = 1'b1;
        EV_LOAD:  int_set[INT_LOAD]  = 1'b1;
        default:  ;
      endcase
      if (evt_err_i) begin
        err_set[ST_CMD] = 1'b1;
        case (evt_kind_e'(evt_kind_i))
          EV_ERASE: err_set[ST_ERASE] = 1'b1;
          EV_PROG:  err_set[ST_PROG]  = 1'b1;
          EV_LOAD:  err_set[ST_LOAD]  = 1'b1;
          default:  ;
        endcase
      end
    end
    if (unk_cmd_i) begin
      int_set[INT_MASTER] = 1'b1;
      err_set[ST_CMD]     = 1'b1;
    end
  end

  // AND-mask write first, then new reports merge on top
  always_comb begin
    int_masked = int_we_i ? (int_q & wr_data_i) : int_q;
    stat_kept  = (int_we_i && !int_masked[INT_MASTER]) ? (stat_q & ~ST_ERR_MASK) : stat_q;
    int_d      = int_masked | int_set;
    stat_d     = stat_kept | err_set;
    if (warm_i) begin
      int_d  = INT_WARM_VAL;
      stat_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q  <= INT_COLD_VAL;
      stat_q <= '0;
    end else begin
      int_q  <= int_d;
      stat_q <= stat_d;
    end
  end

  assign int_o  = int_q;
  assign stat_o = stat_q;

  assert_and_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_we_i && !evt_valid_i && !unk_cmd_i && !warm_i) |=> (int_q == ($past(int_q) & $past(wr_data_i))));

  assert_err_wipe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_we_i && !(int_q[INT_MASTER] && wr_data_i[INT_MASTER]) && !evt_valid_i && !warm_i)
      |=> ((stat_q & ST_ERR_MASK) == '0));

  assert_evt_master_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !warm_i) |=> int_q[INT_MASTER]);

  assert_err_has_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_err_i && !warm_i) |=> stat_q[ST_CMD]);
endmodule

// File: rtl/flash_cfg_regs.sv
module flash_cfg_regs
  import flash_irq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         warm_i,
  input  logic         cfg1_we_i,
  input  logic         cfg2_we_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cfg1_o,
  output logic [W-1:0] cfg2_o,
  output logic         rdy_o
);
  logic [W-1:0] cfg1_q, cfg2_q;
  logic         rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1_q <= CFG1_RST_VAL;
      cfg2_q <= CFG2_RST_VAL;
      rdy_q  <= 1'b1;
    end else if (warm_i) begin
      cfg1_q <= CFG1_RST_VAL;
      cfg2_q <= CFG2_RST_VAL;
      rdy_q  <= 1'b1;
    end else begin
      if (cfg1_we_i) begin
        cfg1_q <= wr_data_i;
        rdy_q  <= wr_data_i[CFG_RDY];
      end
      if (cfg2_we_i) cfg2_q <= wr_data_i;
    end
  end

  assign cfg1_o = cfg1_q;
  assign cfg2_o = cfg2_q;
  assign rdy_o  = rdy_q;

  assert_rdy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg1_we_i && !warm_i) |=> $stable(rdy_q));

  assert_rdy_track_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg1_we_i && !warm_i) |=> (rdy_q == cfg1_q[CFG_RDY]));
endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
  import flash_irq_pkg::*;
#(
  parameter int CW = CMD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          warm_i,
  input  logic          cmd_we_i,
  input  logic [CW-1:0] cmd_data_i,
  input  logic          busy_i,
  output logic          start_o,
  output logic [CW-1:0] cmd_o,
  output logic          unk_o,
  output logic [CW-1:0] last_o
);
  logic          take;
  logic          known;
  logic [CW-1:0] last_q;

  assign known   = cmd_known(cmd_data_i);
  assign take    = cmd_we_i && !busy_i;
  assign start_o = take && known;
  assign unk_o   = take && !known;
  assign cmd_o   = cmd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= '0;
    else if (warm_i) last_q <= '0;
    else if (take)   last_q <= cmd_data_i;
  end

  assign last_o = last_q;

  assert_busy_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && busy_i && !warm_i) |=> $stable(last_q));

  assert_start_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && unk_o));
endmodule

// File: rtl/flash_irq_regs.sv
module flash_irq_regs
  import flash_irq_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int CW = CMD_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          warm_rst_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [W-1:0]  rd_data_o,
  input  logic          evt_valid_i,
  input  logic [1:0]    evt_kind_i,
  input  logic          evt_err_i,
  output logic          cmd_start_o,
  output logic [CW-1:0] cmd_o,
  output logic          irq_o,
  output logic          rdy_o
);
  logic [W-1:0]  int_w, stat_w, cfg1_w, cfg2_w;
  logic [CW-1:0] last_w;
  logic          unk_w;
  logic          we_int, we_cfg1, we_cfg2, we_cmd;

  assign we_int  = wr_en_i && (addr_i == RA_INT);
  assign we_cfg1 = wr_en_i && (addr_i == RA_CFG1);
  assign we_cfg2 = wr_en_i && (addr_i == RA_CFG2);
  assign we_cmd  = wr_en_i && (addr_i == RA_CMD);

  flash_int_ctrl #(.W(W)) u_int (
    .clk_i(clk_i), .rst_ni(rst_ni), .warm_i(warm_rst_i),
    .int_we_i(we_int), .wr_data_i(wr_data_i),
    .evt_valid_i(evt_valid_i), .evt_kind_i(evt_kind_i), .evt_err_i(evt_err_i),
    .unk_cmd_i(unk_w), .int_o(int_w), .stat_o(stat_w)
  );

  flash_cfg_regs #(.W(W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .warm_i(warm_rst_i),
    .cfg1_we_i(we_cfg1), .cfg2_we_i(we_cfg2), .wr_data_i(wr_data_i),
    .cfg1_o(cfg1_w), .cfg2_o(cfg2_w), .rdy_o(rdy_o)
  );

  flash_cmd_gate #(.CW(CW)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .warm_i(warm_rst_i),
    .cmd_we_i(we_cmd), .cmd_data_i(wr_data_i[CW-1:0]), .busy_i(int_w[INT_MASTER]),
    .start_o(cmd_start_o), .cmd_o(cmd_o), .unk_o(unk_w), .last_o(last_w)
  );

  // cfg1 bit 6 set: active high; clear: active low
  assign irq_o = int_w[INT_MASTER] ^ ~cfg1_w[CFG_POL];

  always_comb begin
    case (addr_i)
      RA_INT:  rd_data_o = int_w;
      RA_STAT: rd_data_o = stat_w;
      RA_CFG1: rd_data_o = cfg1_w & CFG1_RD_MASK;
      RA_CFG2: rd_data_o = cfg2_w;
      RA_CMD:  rd_data_o = W'(last_w);
      default: rd_data_o = '0;
    endcase
  end

  assert_unknown_flags_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unk_w && !warm_rst_i) |=> (int_w[INT_MASTER] && stat_w[ST_CMD]));

  assert_warm_vals_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> (int_w == INT_WARM_VAL && cfg1_w == CFG1_RST_VAL && rdy_o));

  assert_stat_wr_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == RA_STAT && !evt_valid_i && !warm_rst_i) |=> $stable(stat_w));
endmodule

// File: tb/flash_irq_regs_bench.sv
module flash_irq_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        warm_rst_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        evt_valid_i = 1'b0;
  logic [1:0]  evt_kind_i = '0;
  logic        evt_err_i = 1'b0;
  logic        cmd_start_o;
  logic [7:0]  cmd_o;
  logic        irq_o, rdy_o;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [15:0] m_int, m_stat, m_cfg1, m_cfg2;
  logic [7:0]  m_last;
  logic        m_rdy;
  // sampled outputs of the last tick
  logic [15:0] s_rd;
  logic        s_start, s_irq, s_rdy;
  logic [7:0]  s_cmd;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_irq_regs u_flash_irq_regs (
    .clk_i(clk), .rst_ni(rst_ni), .warm_rst_i(warm_rst_i),
    .addr_i(addr_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .evt_valid_i(evt_valid_i), .evt_kind_i(evt_kind_i), .evt_err_i(evt_err_i),
    .cmd_start_o(cmd_start_o), .cmd_o(cmd_o), .irq_o(irq_o), .rdy_o(rdy_o)
  );

  function automatic bit known_op(input logic [7:0] c);
    byte unsigned ops[$] = '{8'h00, 8'h13, 8'h80, 8'h1A, 8'h1B, 8'h23, 8'h27, 8'h2A,
                             8'h2C, 8'h71, 8'h95, 8'h94, 8'hB0, 8'h30, 8'hF0, 8'hF3, 8'h65};
    foreach (ops[i]) if (ops[i] == c) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_int;
      3'd1: return m_stat;
      3'd2: return m_cfg1 & 16'hFFE0;
      3'd3: return m_cfg2;
      3'd4: return {8'h00, m_last};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_cold();
    m_int = 16'h8080; m_stat = 0; m_cfg1 = 16'h40C0; m_cfg2 = 0; m_last = 0; m_rdy = 1;
  endtask

  task automatic model_step();
    logic [15:0] nint, nstat;
    bit take;
    if (warm_rst_i) begin
      m_int = 16'h8010; m_stat = 0; m_cfg1 = 16'h40C0; m_cfg2 = 0; m_last = 0; m_rdy = 1;
      return;
    end
    nint = m_int; nstat = m_stat;
    if (wr_en_i && addr_i == 3'd0) begin
      nint = nint & wr_data_i;
      if (nint[15] == 1'b0) nstat[13:10] = 4'b0000;
    end
    take = wr_en_i && addr_i == 3'd4 && !m_int[15];
    if (take) begin
      m_last = wr_data_i[7:0];
      if (!known_op(wr_data_i[7:0])) begin
        nint[15] = 1'b1; nstat[10] = 1'b1;
      end
    end
    if (evt_valid_i) begin
      nint[15] = 1'b1;
      if (evt_kind_i != 2'd3) nint[5 + evt_kind_i] = 1'b1;
      if (evt_err_i) begin
        nstat[10] = 1'b1;
        if (evt_kind_i != 2'd3) nstat[11 + evt_kind_i] = 1'b1;
      end
    end
    if (wr_en_i && addr_i == 3'd2) begin m_cfg1 = wr_data_i; m_rdy = wr_data_i[7]; end
    if (wr_en_i && addr_i == 3'd3) m_cfg2 = wr_data_i;
    m_int = nint; m_stat = nstat;
  endtask

  // compare every output against the model, then advance one clock
  task automatic tick();
    bit exp_start;
    @(negedge clk);
    s_rd = rd_data_o; s_start = cmd_start_o; s_irq = irq_o; s_rdy = rdy_o; s_cmd = cmd_o;
    exp_start = wr_en_i && addr_i == 3'd4 && !m_int[15] && known_op(wr_data_i[7:0]);
    check("R3 irq pin", {15'b0, s_irq}, {15'b0, m_int[15] ^ ~m_cfg1[6]});
    check("R8 ready pin", {15'b0, s_rdy}, {15'b0, m_rdy});
    check("R12/R10 start strobe", {15'b0, s_start}, {15'b0, exp_start});
    if (exp_start) check("R12 cmd_o", {8'b0, s_cmd}, {8'b0, wr_data_i[7:0]});
    check("R4/R7/R9 read data", s_rd, model_rd(addr_i));
    @(posedge clk);
    model_step();
    #1;
  endtask

  task automatic idle();
    wr_en_i = 0; evt_valid_i = 0; evt_err_i = 0; warm_rst_i = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    idle(); addr_i = a; wr_en_i = 1; wr_data_i = d; tick(); idle();
  endtask

  task automatic evt(input logic [1:0] k, input logic e);
    idle(); evt_valid_i = 1; evt_kind_i = k; evt_err_i = e; tick(); idle();
  endtask

  task automatic rd(input logic [2:0] a);
    idle(); addr_i = a; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_cold();
    #(CLK_PERIOD * 2 + 1);
    rst_ni = 1;
    // R1 cold reset values
    rd(3'd0); check("R1 int reset", s_rd, 16'h8080);
    check("R1 irq reset", {15'b0, s_irq}, 16'h0001);
    check("R1 rdy reset", {15'b0, s_rdy}, 16'h0001);
    rd(3'd2); check("R1 cfg1 reset", s_rd, 16'h40C0);
    rd(3'd3); check("R1 cfg2 reset", s_rd, 16'h0000);
    rd(3'd1); check("R1 stat reset", s_rd, 16'h0000);

    // R3/R8/R9 polarity, ready, read mask
    wr(3'd2, 16'h0000);
    rd(3'd2); check("R9 cfg1 zero", s_rd, 16'h0000);
    check("R3 active-low pin", {15'b0, s_irq}, 16'h0000);
    check("R8 ready follows bit7", {15'b0, s_rdy}, 16'h0000);
    wr(3'd2, 16'h005F);
    rd(3'd2); check("R9 cfg1 masked", s_rd, 16'h0040);
    check("R3 active-high pin", {15'b0, s_irq}, 16'h0001);
    wr(3'd3, 16'h1234);
    rd(3'd3); check("R9 cfg2 full", s_rd, 16'h1234);
    check("R8 ready held", {15'b0, s_rdy}, 16'h0000);
    wr(3'd2, 16'h40C0);

    // R10 command while pending
    wr(3'd4, 16'h0094); check("R10 no start when pending", {15'b0, s_start}, 16'h0000);
    rd(3'd4); check("R10 last cmd unchanged", s_rd, 16'h0000);

    // R4 AND clear
    wr(3'd0, 16'h7FFF);
    rd(3'd0); check("R4 and-mask", s_rd, 16'h0080);
    check("R3 pin idle", {15'b0, s_irq}, 16'h0000);

    // R12 accepted
    wr(3'd4, 16'h0094);
    check("R12 start", {15'b0, s_start}, 16'h0001);
    check("R12 opcode", {8'b0, s_cmd}, 16'h0094);
    rd(3'd4); check("R12 last cmd", s_rd, 16'h0094);

    // R6/R7 erase failure
    evt(2'd0, 1);
    rd(3'd0); check("R6 erase done", s_rd, 16'h80A0);
    rd(3'd1); check("R7 erase err", s_rd, 16'h0C00);
    wr(3'd0, 16'hFFDF);
    rd(3'd1); check("R5 errors kept while master set", s_rd, 16'h0C00);
    wr(3'd1, 16'h0000);
    rd(3'd1); check("R13 status write ignored", s_rd, 16'h0C00);
    wr(3'd0, 16'h00FF);
    rd(3'd0); check("R4 master cleared", s_rd, 16'h0080);
    rd(3'd1); check("R5 errors wiped", s_rd, 16'h0000);
    wr(3'd1, 16'hFFFF);
    rd(3'd1); check("R13 status write ignored", s_rd, 16'h0000);

    // R11 unknown opcode
    wr(3'd4, 16'h0042); check("R11 no start", {15'b0, s_start}, 16'h0000);
    rd(3'd0); check("R11 master set", s_rd, 16'h8080);
    rd(3'd1); check("R11 cmd err", s_rd, 16'h0400);
    wr(3'd0, 16'h0000);

    // R7 program and load and other
    evt(2'd1, 1); rd(3'd1); check("R7 prog err", s_rd, 16'h1400);
    wr(3'd0, 16'h0000);
    evt(2'd2, 1); rd(3'd1); check("R7 load err", s_rd, 16'h2400);
    rd(3'd0); check("R6 load done", s_rd, 16'h8080);
    wr(3'd0, 16'h0000);
    evt(2'd3, 1); rd(3'd1); check("R7 other err", s_rd, 16'h0400);
    rd(3'd0); check("R6 other master only", s_rd, 16'h8000);

    // R5 clearing write with a same-cycle report
    idle(); addr_i = 3'd0; wr_en_i = 1; wr_data_i = 16'h0000;
    evt_valid_i = 1; evt_kind_i = 2'd1; evt_err_i = 1; tick(); idle();
    rd(3'd1); check("R5 new report survives clear", s_rd, 16'h1400);
    rd(3'd0); check("R6 prog done after clear", s_rd, 16'h8040);

    // R2 warm reset
    wr(3'd2, 16'h0000); wr(3'd3, 16'hBEEF);
    idle(); warm_rst_i = 1; tick(); idle();
    rd(3'd0); check("R2 int warm", s_rd, 16'h8010);
    check("R2 rdy warm", {15'b0, s_rdy}, 16'h0001);
    rd(3'd2); check("R2 cfg1 warm", s_rd, 16'h40C0);
    rd(3'd3); check("R2 cfg2 warm", s_rd, 16'h0000);
    rd(3'd1); check("R2 stat warm", s_rd, 16'h0000);

    // mixed traffic against the model
    for (int i = 0; i < 2000; i++) begin
      idle();
      addr_i    = 3'($urandom_range(0, 5));
      wr_en_i   = ($urandom_range(0, 2) == 0);
      wr_data_i = 16'($urandom);
      if (addr_i == 3'd4 && $urandom_range(0, 1) == 1) wr_data_i[7:0] = 8'h80;
      if (addr_i == 3'd0 && $urandom_range(0, 1) == 1) wr_data_i[15] = 1'b0;
      evt_valid_i = ($urandom_range(0, 3) == 0);
      evt_kind_i  = 2'($urandom);
      evt_err_i   = 1'($urandom);
      warm_rst_i  = ($urandom_range(0, 99) == 0);
      tick();
    end
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule